// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a bank of already-synchronized pin levels and turns each one into an interrupt request according to per-pin configuration. For every pin, software chooses edge or level sensing, the active polarity, an optional any-edge mode, an optional debounce filter, an enable and a mask. The block reports a raw status vector, a masked status vector and a single combined interrupt line. Register storage and bus decoding sit outside. The configuration arrives as plain vectors, and end-of-interrupt arrives as a one-cycle pulse vector.

Each pin first passes through a filter stage. With debounce off, this stage is a single register. With debounce on, a new level is accepted only after it has held for a set number of debounce ticks. The detector then compares the filtered level with its value one cycle earlier. Edge events are latched until acknowledged. Level conditions are reported live. The combined output is the registered OR of all masked bits. It is meant to drive one line of a system interrupt controller.

Top module: `gpio_irq_detect`

## Requirements
- R1: For an edge-type pin (edge bit = 1), polarity 1 latches status on a 0-to-1 change of the filtered level and polarity 0 latches it on a 1-to-0 change. The latched bit stays set until it is cleared.
- R2: For a level-type pin (edge bit = 0), raw status is 1 whenever the filtered level equals the polarity bit. It is not latched and end-of-interrupt leaves it unchanged.
- R3: For an edge-type pin with the any-edge bit = 1, a change of the filtered level in either direction latches status, whatever the polarity bit is.
- R4: An end-of-interrupt bit of 1 clears that pin's latched edge status on the next clock. A bit of 0 leaves the status unchanged.
- R5: When a qualifying edge and an end-of-interrupt pulse reach the same pin in the same cycle, the latched status ends up set.
- R6: masked_o equals raw_o with every bit whose mask bit is 1 forced to 0. The mask never changes raw_o.
- R7: A pin whose enable bit is 0 shows raw status 0. Dropping the enable also clears that pin's latched edge status, so re-enabling the pin does not bring back an old event.
- R8: irq_o is the OR of all masked_o bits, registered once, so it follows masked_o with one cycle of delay.
- R9: With debounce on, a new pin level reaches detection only after it has differed from the accepted level on DB_TICKS consecutive cycles that carry db_tick_i. A shorter excursion is discarded.
- R10: With debounce off, a pin level reaches detection through exactly one register, and an edge shows in raw_o one cycle after that.
- R11: After reset, the filtered levels, the latched status and irq_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Synchronized pin levels |
| db_tick_i | input | 1 | Debounce clock enable |
| edge_mode_i | input | NUM_PINS | 1 = edge sensing, 0 = level sensing |
| polarity_i | input | NUM_PINS | 1 = rising/high, 0 = falling/low |
| any_edge_i | input | NUM_PINS | 1 = both edges (edge type only) |
| debounce_i | input | NUM_PINS | 1 = debounce filter on |
| enable_i | input | NUM_PINS | Per-pin interrupt enable |
| mask_i | input | NUM_PINS | 1 = hide pin from masked status |
| eoi_i | input | NUM_PINS | One-cycle end-of-interrupt pulses, write-one-to-clear |
| raw_o | output | NUM_PINS | Raw interrupt status |
| masked_o | output | NUM_PINS | Raw status of unmasked pins |
| irq_o | output | 1 | Registered OR of masked status |

## Verification
The hazardous overlap is a new edge arriving in the same cycle as the acknowledge pulse for that pin. If acknowledge wins, the event is silently lost. A directed sequence raises the pin and then pulses end-of-interrupt in the exact cycle that the detector sees the transition. The bench expects the status to remain set, and a second, solitary pulse must then clear it. The random phase also lands acknowledge pulses on edges and on enable drops by chance. A cycle-level reference model, built from the requirements, judges each of those collisions.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  function automatic logic edge_hit(input logic rise, input logic fall,
                                    input logic pol, input logic any);
    if (any) return rise | fall;
    return pol ? rise : fall;
  endfunction
endpackage

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
  parameter int DB_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic db_en_i,
  input  logic pin_i,
  output logic lvl_o
);
  localparam int CW = (DB_TICKS > 1) ? $clog2(DB_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DB_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (!db_en_i) begin
      lvl_q <= pin_i;
      cnt_q <= '0;
    end else if (pin_i == lvl_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        lvl_q <= pin_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
  import gpio_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic edge_mode_i,
  input  logic pol_i,
  input  logic any_i,
  input  logic en_i,
  input  logic eoi_i,
  output logic raw_o
);
  logic prev_q, hit_q;
  logic rise, fall, ev;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;
  assign ev   = en_i & edge_mode_i & edge_hit(rise, fall, pol_i, any_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      // disable wins; a fresh edge outranks the acknowledge
      if (!en_i)      hit_q <= 1'b0;
      else if (ev)    hit_q <= 1'b1;
      else if (eoi_i) hit_q <= 1'b0;
    end
  end

  assign raw_o = en_i & (edge_mode_i ? hit_q : (lvl_i == pol_i));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NUM_PINS = 32,
  parameter int DB_TICKS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                db_tick_i,
  input  logic [NUM_PINS-1:0] edge_mode_i,
  input  logic [NUM_PINS-1:0] polarity_i,
  input  logic [NUM_PINS-1:0] any_edge_i,
  input  logic [NUM_PINS-1:0] debounce_i,
  input  logic [NUM_PINS-1:0] enable_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic [NUM_PINS-1:0] eoi_i,
  output logic [NUM_PINS-1:0] raw_o,
  output logic [NUM_PINS-1:0] masked_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] lvl;
  logic                irq_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_irq_filter #(.DB_TICKS(DB_TICKS)) u_filt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (db_tick_i),
      .db_en_i (debounce_i[i]),
      .pin_i   (pin_i[i]),
      .lvl_o   (lvl[i])
    );
    gpio_irq_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lvl_i       (lvl[i]),
      .edge_mode_i (edge_mode_i[i]),
      .pol_i       (polarity_i[i]),
      .any_i       (any_edge_i[i]),
      .en_i        (enable_i[i]),
      .eoi_i       (eoi_i[i]),
      .raw_o       (raw_o[i])
    );
  end

  assign masked_o = raw_o & ~mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |masked_o;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker #(
  parameter int NUM_PINS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] edge_mode_i,
  input logic [NUM_PINS-1:0] enable_i,
  input logic [NUM_PINS-1:0] mask_i,
  input logic [NUM_PINS-1:0] eoi_i,
  input logic [NUM_PINS-1:0] raw_o,
  input logic [NUM_PINS-1:0] masked_o,
  input logic                irq_o
);
  p_mask_hides_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked_o & mask_i) == '0);
  p_masked_subset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked_o & ~raw_o) == '0);
  p_irq_follows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> irq_o == $past(|masked_o));
  p_disabled_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_o & ~enable_i) == '0);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    p_latch_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_mode_i[i] && enable_i[i] && raw_o[i] && !eoi_i[i])
      |=> (!edge_mode_i[i] || !enable_i[i] || raw_o[i]));
  end
endmodule

bind gpio_irq_detect gpio_irq_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .edge_mode_i (edge_mode_i),
  .enable_i    (enable_i),
  .mask_i      (mask_i),
  .eoi_i       (eoi_i),
  .raw_o       (raw_o),
  .masked_o    (masked_o),
  .irq_o       (irq_o)
);

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;
  localparam int N  = 32;
  localparam int DB = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin = '0, typ = '0, pol = '0, any = '0, dbe = '0;
  logic [N-1:0] en = '0, msk = '0, eoi = '0;
  logic         tick = 1'b0;
  logic [N-1:0] raw, masked;
  logic         irq;

  int checks = 0;
  int bad    = 0;

  always #4 clk = ~clk;

  gpio_irq_detect #(.NUM_PINS(N), .DB_TICKS(DB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .db_tick_i(tick),
    .edge_mode_i(typ), .polarity_i(pol), .any_edge_i(any),
    .debounce_i(dbe), .enable_i(en), .mask_i(msk), .eoi_i(eoi),
    .raw_o(raw), .masked_o(masked), .irq_o(irq)
  );

  // reference model built from the requirements
  logic [N-1:0] m_flt, m_prev, m_hit;
  int           m_cnt [N];
  logic         m_irq;

  function automatic logic [N-1:0] exp_raw();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++)
      r[i] = en[i] & (typ[i] ? m_hit[i] : (m_flt[i] == pol[i]));
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flt <= '0; m_prev <= '0; m_hit <= '0; m_irq <= 1'b0;
      for (int i = 0; i < N; i++) m_cnt[i] <= 0;
    end else begin
      logic [N-1:0] r;
      r = exp_raw();
      m_irq <= |(r & ~msk);
      m_prev <= m_flt;
      for (int i = 0; i < N; i++) begin
        logic rs, fl, ev;
        rs = m_flt[i] & ~m_prev[i];
        fl = ~m_flt[i] & m_prev[i];
        ev = typ[i] & (any[i] ? (rs | fl) : (pol[i] ? rs : fl));
        if (!en[i]) m_hit[i] <= 1'b0;
        else if (ev) m_hit[i] <= 1'b1;
        else if (eoi[i]) m_hit[i] <= 1'b0;
        if (!dbe[i]) begin
          m_flt[i] <= pin[i]; m_cnt[i] <= 0;
        end else if (pin[i] == m_flt[i]) m_cnt[i] <= 0;
        else if (tick) begin
          if (m_cnt[i] == DB - 1) begin m_flt[i] <= pin[i]; m_cnt[i] <= 0; end
          else m_cnt[i] <= m_cnt[i] + 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle model comparison at the falling edge, before new stimulus
  always @(negedge clk) if (rst_n) begin
    logic [N-1:0] r;
    r = exp_raw();
    chk("R1 R2 R3 raw_o vs model", raw, r);
    chk("R6 masked_o vs model", masked, r & ~msk);
    chk("R8 irq_o vs model", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, m_irq});
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic look();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look();
    chk("R11 raw after reset", raw, '0);
    chk("R11 irq after reset", {{(N-1){1'b0}}, irq}, '0);
    #1;

    // R10 / R1: rising edge on pin 0, no debounce
    typ[0] = 1; pol[0] = 1; en[0] = 1;
    step(2);
    pin[0] = 1;
    look(); chk("R10 no event one cycle after pin rise", raw & 1, '0);
    look(); chk("R1 rising edge latched", raw & 1, 1);
    look(); chk("R8 irq one cycle after masked", {{(N-1){1'b0}}, irq}, 1);
    #1; pin[0] = 0;
    step(3);
    chk("R1 latch holds without eoi", raw & 1, 1);
    eoi[0] = 1; step(1); eoi[0] = 0;
    look(); chk("R4 eoi clears latch", raw & 1, 0);
    #1;

    // R6 mask on a latched pin
    msk[0] = 1; pin[0] = 1; step(3);
    chk("R6 raw unaffected by mask", raw & 1, 1);
    chk("R6 masked suppressed", masked & 1, 0);
    msk[0] = 0; eoi[0] = 1; step(1); eoi[0] = 0; step(1);

    // R5: edge and eoi same cycle on pin 2
    typ[2] = 1; pol[2] = 1; en[2] = 1; step(2);
    pin[2] = 1;           // filter updates at next posedge
    step(1); eoi[2] = 1;  // event and eoi share the following posedge
    step(1); eoi[2] = 0;
    look(); chk("R5 edge beats same-cycle eoi", (raw >> 2) & 1, 1);
    #1; eoi[2] = 0; step(2);
    chk("R4 eoi zero leaves latch", (raw >> 2) & 1, 1);

    // R3 any-edge ignores polarity, falling edge with pol=1
    typ[3] = 1; pol[3] = 1; any[3] = 1; pin[3] = 1; step(3);
    en[3] = 1; step(2);
    chk("R3 no event while steady", (raw >> 3) & 1, 0);
    pin[3] = 0; step(3);
    chk("R3 falling edge latches with pol=1", (raw >> 3) & 1, 1);
    // R7: disable clears, re-enable stays clear
    en[3] = 0; step(2);
    chk("R7 disabled pin raw 0", (raw >> 3) & 1, 0);
    en[3] = 1; step(2);
    chk("R7 old event not restored", (raw >> 3) & 1, 0);

    // R2 level high follows pin, eoi no effect
    typ[4] = 0; pol[4] = 1; en[4] = 1; pin[4] = 1; step(2);
    eoi[4] = 1; step(1); eoi[4] = 0; step(1);
    chk("R2 level high active, eoi ignored", (raw >> 4) & 1, 1);
    pin[4] = 0; step(2);
    chk("R2 level drops with pin", (raw >> 4) & 1, 0);

    // R9 debounce: short glitch rejected, long pulse accepted
    typ[5] = 1; pol[5] = 1; en[5] = 1; dbe[5] = 1; tick = 1; step(2);
    pin[5] = 1; step(DB - 1); pin[5] = 0; step(8);
    chk("R9 short glitch rejected", (raw >> 5) & 1, 0);
    pin[5] = 1; step(DB + 2);
    chk("R9 stable level accepted", (raw >> 5) & 1, 1);

    // random phase, compared against the model every cycle
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] flip;
      flip = $urandom() & $urandom() & $urandom();
      pin  = pin ^ flip;
      tick = $urandom_range(0, 1);
      eoi  = $urandom() & $urandom();
      if ($urandom_range(0, 15) == 0) begin
        typ = $urandom(); pol = $urandom(); any = $urandom();
        dbe = $urandom(); en  = $urandom() | $urandom(); msk = $urandom() & $urandom();
      end
      step(1);
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule